// File: doc/BRIEF.md
# Serial Test Cell Chain for Macrocell-Driven I/O Pins

This block is the data-register side of a boundary-scan path for a row of I/O pins. Each pin whose output is produced by core logic gets a cell with three serial stages: output enable, output data and pin input. Each such cell also has two update stages that hold the output enable and output data values used during testing. Pins that are only inputs get a reduced cell with a single stage that records the pin level. All stages form one shift path from `tdi` to `tdo`. An external TAP controller supplies the capture, shift, update and test-mode controls on the test clock.

In functional mode the pins carry the core's own data and enable. In test mode the update stages drive them instead. Capture and shift act on the rising test-clock edge. Update acts on the falling edge, so values scanned into the chain reach the pins only when an update is requested. Values already driven do not ripple while the chain is shifting. The pin input level is always passed straight through to the core.

Top module: `bscan_io_chain`

## Requirements
- R1: While reset is applied and after it is released, all serial and update stages are 0: `tdo` reads 0, and in test mode every `pin_dout` and `pin_oe` bit is 0.
- R2: With `test_mode` = 0, for every full I/O cell, `pin_dout[c]` equals `core_dout[c]` and `pin_oe[c]` equals `core_oe[c]`.
- R3: On a rising `tck` edge with `capture_dr` = 1, each full cell loads `core_oe[c]`, `core_dout[c]` and `pin_in[c]` into its enable, data and pin stages. An input-only cell loads `pin_in[c]`. Capture takes priority over shift when both are asserted.
- R4: On a rising `tck` edge with `shift_dr` = 1 and `capture_dr` = 0, the chain advances one position. Bits flow from `tdi` into cell 0's enable stage, then its data stage, then its pin stage, then into cell 1, and so on. `tdo` is the registered last stage of the highest-numbered cell.
- R5: On a rising `tck` edge with `capture_dr` = 0 and `shift_dr` = 0, every serial stage and `tdo` keep their value.
- R6: On a falling `tck` edge with `update_dr` = 1, each full cell's update stages load the cell's current enable and data serial stages.
- R7: While `update_dr` = 0 the update stages keep their value, so in test mode `pin_dout` and `pin_oe` do not change while the chain shifts or captures.
- R8: With `test_mode` = 1, every full cell drives `pin_dout[c]` from its data update stage and `pin_oe[c]` from its enable update stage.
- R9: A cell selected as input-only by bit c of parameter `IN_ONLY` has a single serial stage and no update stages, and it always drives `pin_dout[c]` = 0 and `pin_oe[c]` = 0.
- R10: `core_din[c]` equals `pin_in[c]` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released on the rising test clock |
| capture_dr | input | 1 | Load live values into the serial stages |
| shift_dr | input | 1 | Advance the serial chain by one position |
| update_dr | input | 1 | Load the update stages on the falling test clock |
| test_mode | input | 1 | 1 selects the update stages to drive the pins |
| tdi | input | 1 | Serial data into the chain |
| core_dout | input | NUM_CELLS | Functional output data from the core |
| core_oe | input | NUM_CELLS | Functional output enable from the core |
| pin_in | input | NUM_CELLS | Level sensed at each pin |
| pin_dout | output | NUM_CELLS | Data actually driven to each pin |
| pin_oe | output | NUM_CELLS | Output enable actually applied to each pin |
| core_din | output | NUM_CELLS | Pin level passed to the core |
| tdo | output | 1 | Serial data out of the chain |

## Verification
The assertions assume that the controls change only away from both test-clock edges. They also assume that no capture, shift or update is requested within two rising edges after reset is released, because the reset synchronizer still holds the stages clear during that time. The bench changes every input one nanosecond after a rising edge. After reset it idles for several cycles before any operation. It compares the chain against a bit-level model that is built from the chain order and the update timing.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // Serial stages of a full I/O cell, in chain order from the cell's input.
  typedef struct packed {
    logic oe;
    logic dout;
    logic pin;
  } io_stage_t;

  // Update stages of a full I/O cell.
  typedef struct packed {
    logic oe;
    logic dout;
  } io_upd_t;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bscan_stage_io.sv
module bscan_stage_io
  import bscan_pkg::*;
(
  input  logic      tck,
  input  logic      rst_n,
  input  logic      cap_en,
  input  logic      shf_en,
  input  logic      ser_in,
  input  io_stage_t par,
  output io_stage_t q,
  output logic      ser_out
);
  io_stage_t q_r;
  io_stage_t q_nxt;
  logic      ld_en;

  always_comb begin
    ld_en = cap_en | shf_en;
    q_nxt = q_r;
    if (cap_en) begin
      q_nxt = par;
    end else if (shf_en) begin
      q_nxt.oe   = ser_in;
      q_nxt.dout = q_r.oe;
      q_nxt.pin  = q_r.dout;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (ld_en) q_r <= q_nxt;
  end

  assign q       = q_r;
  assign ser_out = q_r.pin;

  // R3: capture loads the live values, ahead of shift
  p_capture_r3: assert property (@(posedge tck) disable iff (!rst_n)
    cap_en |=> q_r == $past(par));
  // R4: shift moves every stage one step along the chain
  p_shift_r4: assert property (@(posedge tck) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (q_r.oe == $past(ser_in)) && (q_r.dout == $past(q_r.oe))
                            && (q_r.pin == $past(q_r.dout)));
  // R5: idle cycles keep the chain
  p_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (!shf_en && !cap_en) |=> $stable(q_r));
endmodule

// File: rtl/bscan_stage_in.sv
module bscan_stage_in (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic ser_in,
  input  logic par_pin,
  output logic ser_out
);
  logic pin_r;
  logic pin_nxt;
  logic ld_en;

  always_comb begin
    ld_en   = cap_en | shf_en;
    pin_nxt = cap_en ? par_pin : ser_in;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     pin_r <= 1'b0;
    else if (ld_en) pin_r <= pin_nxt;
  end

  assign ser_out = pin_r;

  // R9: the single stage captures the pin or takes the serial bit
  p_in_stage_r9: assert property (@(posedge tck) disable iff (!rst_n)
    ld_en |=> pin_r == ($past(cap_en) ? $past(par_pin) : $past(ser_in)));
endmodule

// File: rtl/bscan_update_io.sv
module bscan_update_io
  import bscan_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    upd_en,
  input  io_upd_t d,
  output io_upd_t q
);
  io_upd_t q_r;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (upd_en) q_r <= d;
  end

  assign q = q_r;

  // R6: update loads on the falling edge
  p_update_r6: assert property (@(negedge tck) disable iff (!rst_n)
    upd_en |=> q_r == $past(d));
  // R7: without update the driven values stay put
  p_keep_r7: assert property (@(negedge tck) disable iff (!rst_n)
    !upd_en |=> $stable(q_r));
endmodule

// File: rtl/bscan_io_chain.sv
module bscan_io_chain
  import bscan_pkg::*;
#(
  parameter int                   NUM_CELLS = 8,
  parameter logic [NUM_CELLS-1:0] IN_ONLY   = '0,
  parameter int                   SYNC_LEN  = 2
) (
  input  logic                 tck,
  input  logic                 rst_ni,
  input  logic                 capture_dr,
  input  logic                 shift_dr,
  input  logic                 update_dr,
  input  logic                 test_mode,
  input  logic                 tdi,
  input  logic [NUM_CELLS-1:0] core_dout,
  input  logic [NUM_CELLS-1:0] core_oe,
  input  logic [NUM_CELLS-1:0] pin_in,
  output logic [NUM_CELLS-1:0] pin_dout,
  output logic [NUM_CELLS-1:0] pin_oe,
  output logic [NUM_CELLS-1:0] core_din,
  output logic                 tdo
);
  localparam int LINKS = NUM_CELLS + 1;

  logic             rst_n;
  logic [LINKS-1:0] link;

  bscan_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk    (tck),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign link[0]  = tdi;
  assign core_din = pin_in;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    if (IN_ONLY[c]) begin : g_in
      bscan_stage_in u_stage (
        .tck     (tck),
        .rst_n   (rst_n),
        .cap_en  (capture_dr),
        .shf_en  (shift_dr),
        .ser_in  (link[c]),
        .par_pin (pin_in[c]),
        .ser_out (link[c+1])
      );
      assign pin_dout[c] = 1'b0;
      assign pin_oe[c]   = 1'b0;
    end else begin : g_io
      io_stage_t par;
      io_stage_t sq;
      io_upd_t   ud;
      io_upd_t   uq;

      always_comb begin
        par.oe   = core_oe[c];
        par.dout = core_dout[c];
        par.pin  = pin_in[c];
        ud.oe    = sq.oe;
        ud.dout  = sq.dout;
      end

      bscan_stage_io u_stage (
        .tck     (tck),
        .rst_n   (rst_n),
        .cap_en  (capture_dr),
        .shf_en  (shift_dr),
        .ser_in  (link[c]),
        .par     (par),
        .q       (sq),
        .ser_out (link[c+1])
      );

      bscan_update_io u_upd (
        .tck    (tck),
        .rst_n  (rst_n),
        .upd_en (update_dr),
        .d      (ud),
        .q      (uq)
      );

      always_comb begin
        pin_dout[c] = test_mode ? uq.dout : core_dout[c];
        pin_oe[c]   = test_mode ? uq.oe   : core_oe[c];
      end
    end
  end

  assign tdo = link[NUM_CELLS];

  // R5: tdo is registered and holds across idle cycles
  p_tdo_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
    (!capture_dr && !shift_dr) |=> $stable(tdo));
  // R10: pin levels reach the core in every mode
  p_core_din_r10: assert property (@(posedge tck) disable iff (!rst_n)
    core_din == pin_in);
endmodule

// File: tb/sim_bscan_io_chain.sv
module sim_bscan_io_chain;
  localparam int N = 3;
  localparam int L = 7;
  localparam logic [N-1:0] INO = 3'b010;

  logic tck = 1'b0;
  logic rst_ni, capture_dr, shift_dr, update_dr, test_mode, tdi;
  logic [N-1:0] core_dout, core_oe, pin_in;
  logic [N-1:0] pin_dout, pin_oe, core_din;
  logic tdo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // chain model: kind 0 = enable, 1 = data, 2 = pin
  int   kind [L] = '{0, 1, 2, 2, 0, 1, 2};
  int   cel  [L] = '{0, 0, 0, 1, 2, 2, 2};
  logic m    [L];
  logic u_oe [N];
  logic u_do [N];
  logic [15:0] lfsr = 16'hACE1;

  always #4 tck = ~tck;

  bscan_io_chain #(.NUM_CELLS(N), .IN_ONLY(INO)) u0 (
    .tck(tck), .rst_ni(rst_ni), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .test_mode(test_mode), .tdi(tdi),
    .core_dout(core_dout), .core_oe(core_oe), .pin_in(pin_in),
    .pin_dout(pin_dout), .pin_oe(pin_oe), .core_din(core_din), .tdo(tdo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_dout();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++)
      r[c] = INO[c] ? 1'b0 : (test_mode ? u_do[c] : core_dout[c]);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe();
    logic [N-1:0] r;
    for (int c = 0; c < N; c++)
      r[c] = INO[c] ? 1'b0 : (test_mode ? u_oe[c] : core_oe[c]);
    return r;
  endfunction

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // called at posedge+1; returns at the following posedge+1
  task automatic step(input string req, input logic cap, input logic sh,
                      input logic upd, input logic di);
    capture_dr = cap; shift_dr = sh; update_dr = upd; tdi = di;
    @(posedge tck);
    if (upd)
      for (int k = 0; k < L; k++) begin
        if (kind[k] == 0) u_oe[cel[k]] = m[k];
        if (kind[k] == 1) u_do[cel[k]] = m[k];
      end
    if (cap) begin
      for (int k = 0; k < L; k++)
        m[k] = (kind[k] == 0) ? core_oe[cel[k]] :
               (kind[k] == 1) ? core_dout[cel[k]] : pin_in[cel[k]];
    end else if (sh) begin
      for (int k = L - 1; k > 0; k--) m[k] = m[k-1];
      m[0] = di;
    end
    #1;
    chk({req, " tdo"}, {7'd0, tdo}, {7'd0, m[L-1]});
    chk({req, " pin_dout"}, {5'd0, pin_dout}, {5'd0, exp_dout()});
    chk({req, " pin_oe"}, {5'd0, pin_oe}, {5'd0, exp_oe()});
    capture_dr = 0; shift_dr = 0; update_dr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; capture_dr = 0; shift_dr = 0; update_dr = 0; test_mode = 1; tdi = 0;
    core_dout = '1; core_oe = '1; pin_in = '1;
    for (int k = 0; k < L; k++) m[k] = 0;
    for (int c = 0; c < N; c++) begin u_oe[c] = 0; u_do[c] = 0; end
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset pin_oe", {5'd0, pin_oe}, 8'd0);
    chk("R1 reset pin_dout", {5'd0, pin_dout}, 8'd0);
    rst_ni = 1;
    repeat (4) @(posedge tck);
    #1;
    chk("R1 after release tdo", {7'd0, tdo}, 8'd0);
    chk("R1 after release pin_oe", {5'd0, pin_oe}, 8'd0);

    // R2, R9, R10: functional mode sweep over all input combinations
    test_mode = 0;
    for (int p = 0; p < 512; p++) begin
      {core_dout, core_oe, pin_in} = p[8:0];
      #1;
      chk("R2 func pin_dout", {5'd0, pin_dout}, {5'd0, exp_dout()});
      chk("R2 func pin_oe", {5'd0, pin_oe}, {5'd0, exp_oe()});
      chk("R9 input-only cell idle", {6'd0, pin_oe[1], pin_dout[1]}, 8'd0);
      chk("R10 core_din", {5'd0, core_din}, {5'd0, pin_in});
    end
    @(posedge tck); #1;

    // R3, R4: capture every input pattern, then shift it all out
    for (int p = 0; p < 512; p++) begin
      {core_dout, core_oe, pin_in} = p[8:0];
      step("R3 capture", 1, 0, 0, next_bit());
      for (int s = 0; s < L; s++) step("R4 shift", 0, 1, 0, next_bit());
    end

    // R3 priority over shift, R5 idle hold
    core_dout = 3'b101; core_oe = 3'b011; pin_in = 3'b110;
    step("R3 capture beats shift", 1, 1, 0, 1'b1);
    for (int s = 0; s < 4; s++) step("R5 idle hold", 0, 0, 0, next_bit());

    // R6, R7, R8: scan patterns into the update stages in test mode
    test_mode = 1;
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < L; s++) step("R7 no ripple while shifting", 0, 1, 0, next_bit());
      step("R7 capture without update", 1, 0, 0, 1'b0);
      step("R6 R8 update drives pins", 0, 0, 1, 1'b0);
      test_mode = 0; #1;
      chk("R2 back to functional", {5'd0, pin_dout}, {5'd0, exp_dout()});
      chk("R10 core_din test", {5'd0, core_din}, {5'd0, pin_in});
      test_mode = 1; #1;
      chk("R8 test mode pin_oe", {5'd0, pin_oe}, {5'd0, exp_oe()});
      chk("R9 input-only in test mode", {6'd0, pin_oe[1], pin_dout[1]}, 8'd0);
      {core_dout, core_oe, pin_in} = {p[5:0], p[2:0]};
    end
    // R6 update and shift together: update takes pre-shift values
    step("R6 update with shift", 0, 1, 1, 1'b1);
    step("R6 update after shift", 0, 0, 1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule